// File: doc/BRIEF.md
# Byte-Mode NOR Flash Command Sequencer

This block drives a parallel NOR flash that is strapped for 8-bit operation. A host hands it one command at a time over a ready/valid request with a one-cycle acknowledge. The sequencer expands the command into the bus cycles the flash expects, with chip-enable, write-strobe and read-strobe timing. It then returns a byte and an error flag with the acknowledge.

Unlock and command writes use byte-mode addresses. The host address bit 0 feeds the flash's extra lowest address line, so the word-mode pattern appears shifted up by one bit. Only the lowest twelve flash address lines take part in command decoding, and the sequencer drives the upper bits to zero during command cycles. Program and erase do not finish on their last write. The block keeps reading the target location and watches DQ7 until the flash reports completion. If the flash does not report completion within a host-supplied number of reads, it gives up and flags an error.

Top module: `nor_cmd_seq`

## Requirements
- R1: During and right after reset, fl_ce_n, fl_we_n and fl_oe_n are 1, fl_dq_oe and ack are 0, and req_ready is 1.
- R2: The command codes on req_op are 0 reset, 1 autoselect, 2 read, 3 CFI query, 4 byte program and 5 chip erase. Chip erase issues exactly six writes: 0xAAA/0xAA, 0x555/0x55, 0xAAA/0x80, 0xAAA/0xAA, 0x555/0x55, 0xAAA/0x10. In every fixed-address command write, the address bits above bit 11 are 0.
- R3: Autoselect issues 0xAAA/0xAA, 0x555/0x55 and 0xAAA/0x90 and performs no read. After it, read commands at offsets 0x00 and 0x02 return the manufacturer and device IDs.
- R4: Byte program issues 0xAAA/0xAA, 0x555/0x55 and 0xAAA/0xA0, then req_wdata to req_addr. It then reads req_addr until DQ7 equals bit 7 of req_wdata, and acknowledges with rsp_err=0 and rsp_data equal to that last read.
- R5: After its writes, chip erase reads req_addr until DQ7 is 1, then acknowledges with rsp_err=0 and the last read byte.
- R6: If poll_limit reads in a row fail to show completion, the command acknowledges with rsp_err=1. A poll_limit of 0 behaves as 1.
- R7: A CFI query is one write of 0x98 to address 0x0AA.
- R8: Reset is one write of 0xF0 to address 0, after which reads return array data.
- R9: Read performs one read cycle at req_addr and returns its byte with rsp_err=0. Commands that read nothing return rsp_data=0.
- R10: In each write, fl_we_n stays low for exactly WE_PULSE clocks. Address and data are driven with fl_dq_oe=1 and fl_ce_n=0 at least one clock before fl_we_n falls, and stay unchanged until at least one clock after it rises.
- R11: In each read, fl_oe_n stays low for exactly OE_PULSE clocks with fl_we_n high and fl_dq_oe=0. The returned byte is the one present in the last low clock.
- R12: Codes 6 and 7 are acknowledged on the next cycle with rsp_err=1 and cause no bus cycle.
- R13: A request is taken only when req_valid and req_ready are both 1. req_ready then stays 0 until the single-cycle ack has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host presents a command |
| req_ready | output | 1 | Sequencer idle and able to take a command |
| req_op | input | 3 | Command code |
| req_addr | input | AW | Byte address for read, program and poll |
| req_wdata | input | 8 | Byte to program |
| poll_limit | input | TW | Maximum completion-poll reads |
| ack | output | 1 | One-cycle completion pulse |
| rsp_data | output | 8 | Byte returned with ack |
| rsp_err | output | 1 | Illegal command or poll timeout |
| fl_addr | output | AW | Flash byte address, bit 0 to the lowest line |
| fl_dq_out | output | 8 | Data driven to the flash |
| fl_dq_oe | output | 1 | Enable for fl_dq_out onto the data bus |
| fl_dq_in | input | 8 | Data read from the flash |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
A wrong step index or opcode decode shows up on the first write strobe of the command: the flash model sees an address/data pair that breaks its unlock sequence, and it shows at the latest in the write and read counts checked at that command's acknowledge. A broken poll counter or poll-match decode shows within one command, as a wrong number of poll reads, a wrong error flag or a wrong returned byte. A fault in the cycle engine's strobe counter shows on the very next strobe as a pulse of the wrong width, or as an address that moves while the strobe is low.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  localparam logic [2:0] OP_RESET   = 3'd0;
  localparam logic [2:0] OP_AUTOSEL = 3'd1;
  localparam logic [2:0] OP_READ    = 3'd2;
  localparam logic [2:0] OP_CFI     = 3'd3;
  localparam logic [2:0] OP_PROG    = 3'd4;
  localparam logic [2:0] OP_ERASE   = 3'd5;

  localparam logic [11:0] ADR_HI_KEY = 12'hAAA;
  localparam logic [11:0] ADR_LO_KEY = 12'h555;
  localparam logic [11:0] ADR_QUERY  = 12'h0AA;

  // One bus cycle of a command: write or read, fixed or target address,
  // fixed or host-supplied data.
  typedef struct packed {
    logic        wr;
    logic        tgt;
    logic [11:0] cmd_a;
    logic        own_d;
    logic [7:0]  cmd_d;
  } step_t;

  function automatic logic [2:0] step_count(input logic [2:0] op);
    case (op)
      OP_RESET:   return 3'd1;
      OP_AUTOSEL: return 3'd3;
      OP_READ:    return 3'd1;
      OP_CFI:     return 3'd1;
      OP_PROG:    return 3'd4;
      OP_ERASE:   return 3'd6;
      default:    return 3'd0;
    endcase
  endfunction

  function automatic logic needs_poll(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_ERASE);
  endfunction

  // Completion test on a poll read: DQ7 shows the true bit once done.
  function automatic logic poll_hit(input logic [2:0] op, input logic [7:0] q,
                                    input logic [7:0] wd);
    if (op == OP_PROG) return q[7] == wd[7];
    return q[7];
  endfunction

  function automatic step_t step_at(input logic [2:0] op, input logic [2:0] idx);
    step_t s;
    s = '{wr: 1'b1, tgt: 1'b0, cmd_a: 12'h000, own_d: 1'b0, cmd_d: 8'h00};
    case (op)
      OP_RESET: s.cmd_d = 8'hF0;
      OP_CFI: begin
        s.cmd_a = ADR_QUERY;
        s.cmd_d = 8'h98;
      end
      OP_READ: begin
        s.wr  = 1'b0;
        s.tgt = 1'b1;
      end
      default: begin
        case (idx)
          3'd0, 3'd3: begin
            s.cmd_a = ADR_HI_KEY;
            s.cmd_d = 8'hAA;
            if (idx == 3'd3 && op == OP_PROG) begin
              s.tgt   = 1'b1;
              s.own_d = 1'b1;
            end
          end
          3'd1, 3'd4: begin
            s.cmd_a = ADR_LO_KEY;
            s.cmd_d = 8'h55;
          end
          3'd2: begin
            s.cmd_a = ADR_HI_KEY;
            s.cmd_d = (op == OP_AUTOSEL) ? 8'h90 :
                      (op == OP_PROG)    ? 8'hA0 : 8'h80;
          end
          default: begin
            s.cmd_a = ADR_HI_KEY;
            s.cmd_d = 8'h10;
          end
        endcase
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int AW       = 23,
  parameter int WE_PULSE = 3,
  parameter int OE_PULSE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic          fin,
  output logic [7:0]    rdata,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  localparam int LONGEST = (WE_PULSE > OE_PULSE) ? WE_PULSE : OE_PULSE;
  localparam int CW      = $clog2(LONGEST + 1);

  typedef enum logic [1:0] {C_IDLE, C_SETUP, C_STROBE, C_HOLD} cyc_e;

  cyc_e          st;
  logic [CW-1:0] cnt;
  logic          wr_q;
  logic [AW-1:0] a_q;
  logic [7:0]    d_q;

  logic [CW-1:0] span_last;
  logic          strobe_end;
  assign span_last  = wr_q ? CW'(WE_PULSE - 1) : CW'(OE_PULSE - 1);
  assign strobe_end = (st == C_STROBE) && (cnt == span_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= C_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
      a_q   <= '0;
      d_q   <= '0;
      fin   <= 1'b0;
      rdata <= '0;
    end else begin
      fin <= 1'b0;
      case (st)
        C_IDLE: if (start) begin
          wr_q <= wr;
          a_q  <= addr;
          d_q  <= wdata;
          st   <= C_SETUP;
        end
        C_SETUP: begin
          cnt <= '0;
          st  <= C_STROBE;
        end
        C_STROBE: begin
          cnt <= cnt + 1'b1;
          if (strobe_end) begin
            st <= C_HOLD;
            if (!wr_q) rdata <= fl_dq_in;
          end
        end
        default: begin
          st  <= C_IDLE;
          fin <= 1'b1;
        end
      endcase
    end
  end

  assign fl_addr   = a_q;
  assign fl_dq_out = d_q;
  assign fl_dq_oe  = wr_q && (st != C_IDLE);
  assign fl_ce_n   = (st == C_IDLE);
  assign fl_we_n   = !((st == C_STROBE) && wr_q);
  assign fl_oe_n   = !((st == C_STROBE) && !wr_q);

  // R10 R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
  // R10
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_we_n) |-> $past(!fl_ce_n && fl_dq_oe));
  // R10
  we_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (!fl_ce_n && fl_dq_oe && $stable(fl_addr)));
  // R11
  oe_bus_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          bump,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] used;

  // True when the poll read now finishing is the last one allowed.
  function automatic logic out_of_tries(input logic [TW-1:0] n, input logic [TW-1:0] lim);
    return ({1'b0, n} + (TW + 1)'(1)) >= {1'b0, lim};
  endfunction

  assign expired = out_of_tries(used, limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) used <= '0;
    else if (bump)     used <= used + 1'b1;
  end
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW       = 23,
  parameter int TW       = 16,
  parameter int WE_PULSE = 3,
  parameter int OE_PULSE = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  input  logic [TW-1:0] poll_limit,
  output logic          ack,
  output logic [7:0]    rsp_data,
  output logic          rsp_err,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_dq_out,
  output logic          fl_dq_oe,
  input  logic [7:0]    fl_dq_in,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_ACK} seq_e;

  seq_e          st;
  logic [2:0]    op_q;
  logic [AW-1:0] tgt_q;
  logic [7:0]    wd_q;
  logic [2:0]    idx_q;
  logic          polling_q;

  step_t         cur_step;
  logic [2:0]    step_total;
  logic          on_last;
  logic          cyc_start, cyc_fin, cyc_wr;
  logic [AW-1:0] cyc_addr;
  logic [7:0]    cyc_data, cyc_rdata;
  logic          poll_ok, poll_miss, tries_out;
  logic          take;

  assign take       = req_valid && req_ready;
  assign cur_step   = step_at(op_q, idx_q);
  assign step_total = step_count(op_q);
  assign on_last    = (idx_q == step_total - 3'd1);
  assign cyc_start  = (st == S_ISSUE);
  assign cyc_wr     = !polling_q && cur_step.wr;
  assign cyc_addr   = (polling_q || cur_step.tgt) ? tgt_q : AW'(cur_step.cmd_a);
  assign cyc_data   = cur_step.own_d ? wd_q : cur_step.cmd_d;
  assign poll_ok    = polling_q && cyc_fin && poll_hit(op_q, cyc_rdata, wd_q);
  assign poll_miss  = polling_q && cyc_fin && !poll_hit(op_q, cyc_rdata, wd_q);

  nor_bus_cycle #(.AW(AW), .WE_PULSE(WE_PULSE), .OE_PULSE(OE_PULSE)) u_cyc (
    .clk(clk), .rst_n(rst_n), .start(cyc_start), .wr(cyc_wr), .addr(cyc_addr),
    .wdata(cyc_data), .fin(cyc_fin), .rdata(cyc_rdata),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  nor_poll_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(st == S_IDLE), .bump(poll_miss),
    .limit(poll_limit), .expired(tries_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= '0;
      tgt_q     <= '0;
      wd_q      <= '0;
      idx_q     <= '0;
      polling_q <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          op_q      <= req_op;
          tgt_q     <= req_addr;
          wd_q      <= req_wdata;
          idx_q     <= '0;
          polling_q <= 1'b0;
          rsp_data  <= '0;
          rsp_err   <= (step_count(req_op) == 3'd0);
          st        <= (step_count(req_op) == 3'd0) ? S_ACK : S_ISSUE;
        end
        S_ISSUE: st <= S_WAIT;
        S_WAIT: if (cyc_fin) begin
          if (!cyc_wr) rsp_data <= cyc_rdata;
          if (polling_q) begin
            if (poll_ok) st <= S_ACK;
            else if (tries_out) begin
              rsp_err <= 1'b1;
              st      <= S_ACK;
            end else st <= S_ISSUE;
          end else if (on_last) begin
            if (needs_poll(op_q)) begin
              polling_q <= 1'b1;
              st        <= S_ISSUE;
            end else st <= S_ACK;
          end else begin
            idx_q <= idx_q + 3'd1;
            st    <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign ack       = (st == S_ACK);

  // R13
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R13
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !req_ready);
  // R12
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && req_op >= 3'd6) |=> (ack && rsp_err));
  // R4 R5
  poll_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (polling_q && !fl_ce_n) |-> fl_we_n);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (fl_we_n && fl_oe_n));
endmodule

// File: tb/nor_cmd_seq_test.sv
module nor_cmd_seq_test;
  localparam int AW = 23, TW = 16, WEP = 3, OEP = 2;
  localparam int PROG_BUSY = 3, ERASE_BUSY = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready, ack, rsp_err;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_wdata = '0, rsp_data;
  logic [TW-1:0] poll_limit = 16'd20;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_dq_out, fl_dq_in;
  logic          fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

  nor_cmd_seq #(.AW(AW), .TW(TW), .WE_PULSE(WEP), .OE_PULSE(OEP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .poll_limit(poll_limit), .ack(ack), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
    .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
  );

  int checks = 0, errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural flash model ----------------
  logic [7:0] mem [0:255];
  int  mode = 0;    // 0 array, 1 autoselect, 2 query
  int  wstep = 0, busy = 0, bad = 0, n_wr = 0, n_rd = 0;
  bit  stuck = 1'b0;
  logic [AW-1:0] fall_addr;

  always @* begin
    fl_dq_in = 8'h00;
    if (!fl_ce_n && !fl_oe_n) begin
      if (mode == 1)      fl_dq_in = (fl_addr[7:0] == 8'h00) ? 8'h01 :
                                     (fl_addr[7:0] == 8'h02) ? 8'h7E : 8'h00;
      else if (mode == 2) fl_dq_in = (fl_addr[7:0] == 8'h20) ? 8'h51 : 8'h00;
      else if (busy > 0)  fl_dq_in = {~mem[fl_addr[7:0]][7], mem[fl_addr[7:0]][6:0]};
      else                fl_dq_in = mem[fl_addr[7:0]];
    end
  end

  always @(posedge fl_oe_n) if (rst_n) begin
    n_rd++;
    if (busy > 0 && !stuck) busy--;
  end

  always @(negedge fl_we_n) if (rst_n) fall_addr = fl_addr;

  function automatic bit key(input logic [AW-1:0] a, input logic [11:0] k);
    return a == AW'(k);
  endfunction

  always @(posedge fl_we_n) if (rst_n) begin
    n_wr++;
    // R10 address unchanged across the strobe, bus driven, chip enabled
    check(fl_addr == fall_addr && fl_dq_oe && !fl_ce_n, "R10 write hold", fl_addr, fall_addr);
    if (fl_dq_out == 8'hF0 && wstep != 10) begin mode = 0; wstep = 0; end
    else case (wstep)
      0: if (key(fl_addr, 12'hAAA) && fl_dq_out == 8'hAA) wstep = 1;
         else if (key(fl_addr, 12'h0AA) && fl_dq_out == 8'h98) mode = 2;
         else bad++;
      1: if (key(fl_addr, 12'h555) && fl_dq_out == 8'h55) wstep = 2; else begin bad++; wstep = 0; end
      2: begin
        if (!key(fl_addr, 12'hAAA)) bad++;
        if (fl_dq_out == 8'h90) begin mode = 1; wstep = 0; end
        else if (fl_dq_out == 8'hA0) wstep = 10;
        else if (fl_dq_out == 8'h80) wstep = 3;
        else begin bad++; wstep = 0; end
      end
      3: if (key(fl_addr, 12'hAAA) && fl_dq_out == 8'hAA) wstep = 4; else begin bad++; wstep = 0; end
      4: if (key(fl_addr, 12'h555) && fl_dq_out == 8'h55) wstep = 5; else begin bad++; wstep = 0; end
      5: begin
        if (key(fl_addr, 12'hAAA) && fl_dq_out == 8'h10) begin
          for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
          busy = ERASE_BUSY;
        end else bad++;
        wstep = 0;
      end
      10: begin mem[fl_addr[7:0]] = fl_dq_out; busy = PROG_BUSY; wstep = 0; end
      default: begin bad++; wstep = 0; end
    endcase
  end

  // ---------------- strobe width monitor (R10, R11) ----------------
  int wl = 0, ol = 0;
  always @(negedge clk) if (rst_n) begin
    if (!fl_we_n) wl++;
    else if (wl != 0) begin check(wl == WEP, "R10 we width", wl, WEP); wl = 0; end
    if (!fl_oe_n) begin
      ol++;
      if (ol == 1) check(fl_we_n && !fl_dq_oe, "R11 read bus", {fl_we_n, fl_dq_oe}, 2'b10);
    end else if (ol != 0) begin check(ol == OEP, "R11 oe width", ol, OEP); ol = 0; end
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] d; bit err; string tag; } exp_t;
  exp_t sbq[$];
  int acks = 0;

  always @(negedge clk) if (rst_n && ack) begin
    acks++;
    if (sbq.size() == 0) check(1'b0, "R13 unexpected ack", 1, 0);
    else begin
      exp_t e;
      e = sbq.pop_front();
      check(rsp_err == e.err, {e.tag, " rsp_err"}, rsp_err, e.err);
      check(rsp_data == e.d, {e.tag, " rsp_data"}, rsp_data, e.d);
    end
  end

  task automatic run(input logic [2:0] op, input logic [AW-1:0] a, input logic [7:0] wd,
                     input logic [7:0] ed, input bit ee, input string tag,
                     input int ewr, input int erd);
    int a0, w0, r0;
    exp_t e;
    e.d = ed; e.err = ee; e.tag = tag;
    sbq.push_back(e);
    a0 = acks; w0 = n_wr; r0 = n_rd;
    @(negedge clk);
    check(req_ready, {tag, " R13 ready"}, req_ready, 1);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, {tag, " R13 busy"}, req_ready, 0);
    while (acks == a0) @(negedge clk);
    @(negedge clk);
    check(!ack, {tag, " R13 ack pulse"}, ack, 0);
    check(n_wr - w0 == ewr, {tag, " write count"}, n_wr - w0, ewr);
    check(n_rd - r0 == erd, {tag, " read count"}, n_rd - r0, erd);
  endtask

  task automatic finish_up;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(fl_ce_n && fl_we_n && fl_oe_n, "R1 strobes idle", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    check(!fl_dq_oe && !ack && req_ready, "R1 idle outputs", {fl_dq_oe, ack, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    check(fl_ce_n && req_ready && !ack, "R1 after reset", {fl_ce_n, req_ready, ack}, 3'b110);

    run(3'd0, '0, 8'h00, 8'h00, 0, "R8 reset", 1, 0);
    run(3'd5, 23'h000010, 8'h00, 8'hFF, 0, "R2 R5 erase", 6, ERASE_BUSY + 1);
    run(3'd4, 23'h000123, 8'h3C, 8'h3C, 0, "R4 program low bit7", 4, PROG_BUSY + 1);
    run(3'd2, 23'h000123, 8'h00, 8'h3C, 0, "R9 read back", 0, 1);
    run(3'd4, 23'h000045, 8'hA5, 8'hA5, 0, "R4 program high bit7", 4, PROG_BUSY + 1);
    run(3'd2, 23'h000045, 8'h00, 8'hA5, 0, "R9 read second", 0, 1);
    run(3'd4, 23'h401234, 8'h77, 8'h77, 0, "R2 R4 program high address", 4, PROG_BUSY + 1);
    run(3'd2, 23'h000034, 8'h00, 8'h77, 0, "R9 read third", 0, 1);
    run(3'd2, 23'h000010, 8'h00, 8'hFF, 0, "R5 erased byte", 0, 1);
    run(3'd1, '0, 8'h00, 8'h00, 0, "R3 autoselect", 3, 0);
    run(3'd2, 23'h000000, 8'h00, 8'h01, 0, "R3 maker id", 0, 1);
    run(3'd2, 23'h000002, 8'h00, 8'h7E, 0, "R3 device id", 0, 1);
    run(3'd0, '0, 8'h00, 8'h00, 0, "R8 reset exit", 1, 0);
    run(3'd2, 23'h000123, 8'h00, 8'h3C, 0, "R8 array again", 0, 1);
    run(3'd3, '0, 8'h00, 8'h00, 0, "R7 cfi", 1, 0);
    run(3'd2, 23'h000020, 8'h00, 8'h51, 0, "R7 query byte", 0, 1);
    run(3'd0, '0, 8'h00, 8'h00, 0, "R8 reset cfi", 1, 0);
    run(3'd6, '0, 8'h00, 8'h00, 1, "R12 code 6", 0, 0);
    run(3'd7, '0, 8'h00, 8'h00, 1, "R12 code 7", 0, 0);

    stuck = 1'b1;
    poll_limit = 16'd5;
    run(3'd4, 23'h000010, 8'h00, 8'h80, 1, "R6 timeout 5", 4, 5);
    poll_limit = 16'd0;
    run(3'd4, 23'h000011, 8'h00, 8'h80, 1, "R6 limit zero", 4, 1);
    stuck = 1'b0; busy = 0;
    poll_limit = 16'd20;

    check(bad == 0, "R2 unlock protocol errors", bad, 0);
    check(sbq.size() == 0, "R13 pending responses", sbq.size(), 0);
    finish_up();
  end
endmodule